// File: doc/BRIEF.md
# Bit-Width Pulse Serial Transmitter

This block turns bytes into a train of pulses whose width encodes each bit. A byte arrives through a valid/ready port and waits in a one-byte holding slot. It then moves into a shift register and goes out most significant bit first, one bit per baud tick. Every baud tick starts a new bit period. The tick sets the pulse counter back to zero and drives the output high. The output falls when the counter reaches a compare value. That compare value is taken from one of two inputs, picked by the bit being sent, so a 0 and a 1 produce pulses of two different lengths.

The counter advances only on cycles where the count enable is high. Tying the enable high runs the counter from the block clock; driving it from a slower strobe lets an outside time base set the pulse width. The counter wraps at its full range. In repeat mode every later match toggles the output again. In single-action mode only the first match after a restart has any effect, so a bit period can be much longer than the counter range without extra edges. The baud ticks come from outside the block.

Back-pressure: `s_ready` is high exactly when the holding slot is empty. A byte transfers on a clock edge where `s_valid` and `s_ready` are both high. While `s_ready` is low, the values on `s_valid` and `s_data` are ignored. The slot empties when its byte moves into the shift register.

Top module: `bitpulse_tx`

## Requirements
- R1: After reset, and whenever no byte is being sent, `pulse_out` and `byte_done` are low and `s_ready` is high. A baud tick with an empty slot leaves `pulse_out` low.
- R2: The holding slot stores one byte. `s_ready` is high only while the slot is empty. A byte offered while `s_ready` is low is not taken and does not overwrite the stored byte.
- R3: A baud tick that arrives while idle with a byte in the slot moves that byte into the shift register and starts its first bit period. The edge after the tick sees `s_ready` high again.
- R4: Bits leave most significant bit first, one bit per baud tick, with 8 bit periods per byte.
- R5: At the edge that takes a tick, `pulse_out` goes high and the counter restarts at zero. `pulse_out` falls at the edge where the counter reaches C, so it is high for C counted cycles. C is `cmp_one` for a 1 bit and `cmp_zero` for a 0 bit.
- R6: When the selected compare value is 0, `pulse_out` stays low for the whole bit period.
- R7: The counter advances only on cycles with `cnt_en` high. With `cnt_en` held low, a nonzero-width pulse stays high for the whole bit period.
- R8: The counter wraps at 2^CW. With `single_act` low, every later match toggles `pulse_out`. With `single_act` high, only the first match after a restart acts.
- R9: The compare value is captured at the start of each bit period. Changes to `cmp_zero` or `cmp_one` in the middle of a bit do not affect that bit.
- R10: The tick that ends the eighth bit raises `byte_done` for exactly one cycle. On that same tick a waiting byte starts at once. If no byte is waiting, `pulse_out` goes low at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Counter advance enable |
| baud_tick | input | 1 | One-cycle strobe that starts each bit period |
| s_valid | input | 1 | Byte offered on `s_data` |
| s_data | input | DW | Byte to send |
| s_ready | output | 1 | Holding slot empty; byte accepted when `s_valid` is also high |
| cmp_zero | input | CW | Pulse width for a 0 bit |
| cmp_one | input | CW | Pulse width for a 1 bit |
| single_act | input | 1 | Only the first compare match after a restart acts |
| pulse_out | output | 1 | Width-coded pulse output |
| byte_done | output | 1 | One-cycle flag when the last bit of a byte ends |

## Verification
The directed patterns each isolate one behaviour:
- Alternating and mixed bytes with distinct widths for 0 and 1 show whether the bit order and the compare selection are right.
- A zero compare value separates "no pulse" from a one-cycle pulse.
- A width longer than the bit period shows that the pulse is cut off by the next tick.
- Holding `cnt_en` low shows that the counter freezes.

Bit periods longer than the counter range, run once in repeat mode and once in single-action mode, show whether later wrap-around matches are acted on. Random streams of chained bytes use random periods and widths. During those streams the compare inputs are scrambled in the middle of every bit, and a byte is offered while the slot is full. These show whether compare capture, the hand-over between bytes and back-pressure hold up.

// File: rtl/pwtx_pkg.sv
package pwtx_pkg;
  // compare value source for a bit period
  typedef enum logic {
    SEL_ZERO = 1'b0,
    SEL_ONE  = 1'b1
  } cmp_sel_e;
endpackage

// File: rtl/pwtx_slot.sv
module pwtx_slot #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  input  logic [DW-1:0] s_data,
  output logic          s_ready,
  input  logic          take,
  output logic          full,
  output logic [DW-1:0] held
);
  assign s_ready = !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      held <= '0;
    end else if (take) begin
      full <= 1'b0;
    end else if (s_valid && !full) begin
      full <= 1'b1;
      held <= s_data;
    end
  end
endmodule

// File: rtl/pwtx_shifter.sv
module pwtx_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          full,
  input  logic [DW-1:0] held,
  output logic          take,
  output logic          start,
  output logic          stop,
  output logic          bit_next,
  output logic          busy,
  output logic          byte_done
);
  localparam int BW = $clog2(DW + 1);

  logic [DW-1:0] sh;
  logic [BW-1:0] left;
  logic          last, load, adv;

  assign last     = busy && (left == BW'(1));
  assign load     = tick && full && (!busy || last);
  assign adv      = tick && busy && !last;
  assign start    = load || adv;
  assign stop     = tick && last && !full;
  assign take     = load;
  assign bit_next = load ? held[DW-1] : sh[DW-2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh        <= '0;
      left      <= '0;
      busy      <= 1'b0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= tick && last;
      if (load) begin
        sh   <= held;
        left <= BW'(DW);
        busy <= 1'b1;
      end else if (adv) begin
        sh   <= {sh[DW-2:0], 1'b0};
        left <= left - BW'(1);
      end else if (stop) begin
        busy <= 1'b0;
        left <= '0;
      end
    end
  end
endmodule

// File: rtl/pwtx_pulse.sv
module pwtx_pulse #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          stop,
  input  logic          bit_next,
  input  logic          busy,
  input  logic          cnt_en,
  input  logic [CW-1:0] cmp_zero,
  input  logic [CW-1:0] cmp_one,
  input  logic          single_act,
  output logic          pulse,
  output logic [CW-1:0] cmp_q
);
  import pwtx_pkg::*;

  logic [CW-1:0] cnt, cnt_inc, cmp_new;
  logic          fired, hit;
  cmp_sel_e      sel;

  assign sel     = cmp_sel_e'(bit_next);
  assign cmp_new = (sel == SEL_ONE) ? cmp_one : cmp_zero;
  assign cnt_inc = cnt + CW'(1);
  assign hit     = (cnt_inc == cmp_q) && (cmp_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      cmp_q <= '0;
      pulse <= 1'b0;
      fired <= 1'b0;
    end else if (start) begin
      cnt   <= '0;
      cmp_q <= cmp_new;
      pulse <= (cmp_new != '0);
      fired <= 1'b0;
    end else if (stop || !busy) begin
      cnt   <= '0;
      pulse <= 1'b0;
      fired <= 1'b0;
    end else if (cnt_en) begin
      cnt <= cnt_inc;
      if (hit && !(single_act && fired)) begin
        pulse <= !pulse;
        fired <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bitpulse_tx.sv
module bitpulse_tx #(
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          baud_tick,
  input  logic          s_valid,
  input  logic [DW-1:0] s_data,
  output logic          s_ready,
  input  logic [CW-1:0] cmp_zero,
  input  logic [CW-1:0] cmp_one,
  input  logic          single_act,
  output logic          pulse_out,
  output logic          byte_done
);
  logic          take, full, start, stop, bit_next, busy;
  logic [DW-1:0] held;
  logic [CW-1:0] cmp_q;

  pwtx_slot #(.DW(DW)) u_slot (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data),
    .s_ready(s_ready), .take(take), .full(full), .held(held)
  );

  pwtx_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .full(full), .held(held),
    .take(take), .start(start), .stop(stop), .bit_next(bit_next),
    .busy(busy), .byte_done(byte_done)
  );

  pwtx_pulse #(.CW(CW)) u_pulse (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .bit_next(bit_next), .busy(busy), .cnt_en(cnt_en),
    .cmp_zero(cmp_zero), .cmp_one(cmp_one), .single_act(single_act),
    .pulse(pulse_out), .cmp_q(cmp_q)
  );
endmodule

// File: rtl/pwtx_chk.sv
module pwtx_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          baud_tick,
  input logic          s_valid,
  input logic          s_ready,
  input logic          pulse_out,
  input logic          byte_done,
  input logic          busy,
  input logic [CW-1:0] cmp_q
);
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !pulse_out); // R1
  AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready); // R2
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_ready && !baud_tick) |=> !s_ready); // R2
  AST_ZERO_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmp_q == '0) |-> !pulse_out); // R6
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !byte_done); // R10
  AST_DONE_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> $past(baud_tick)); // R10
endmodule

bind bitpulse_tx pwtx_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .s_valid(s_valid),
  .s_ready(s_ready), .pulse_out(pulse_out), .byte_done(byte_done),
  .busy(busy), .cmp_q(cmp_q)
);

// File: tb/sim_bitpulse_tx.sv
`timescale 1ns/1ps
module sim_bitpulse_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_en = 1'b1;
  logic       baud_tick = 1'b0;
  logic       s_valid = 1'b0;
  logic [7:0] s_data = '0;
  logic       s_ready;
  logic [7:0] cmp_zero = '0;
  logic [7:0] cmp_one = '0;
  logic       single_act = 1'b1;
  logic       pulse_out;
  logic       byte_done;

  int tests = 0;
  int fails = 0;
  logic [7:0] bytes [0:7];

  always #2 clk = ~clk;

  bitpulse_tx u0 (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .baud_tick(baud_tick),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .cmp_zero(cmp_zero), .cmp_one(cmp_one), .single_act(single_act),
    .pulse_out(pulse_out), .byte_done(byte_done)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // high samples in a bit period of p cycles for width c
  function automatic int exp_high(int c, int p, bit single, bit en);
    int st = 1, fired = 0, n = 0;
    if (c == 0) return 0;
    if (!en) return p;
    for (int k = 0; k < p; k++) begin
      if (k > 0 && (k % 256) == c && (!single || fired == 0)) begin
        st = 1 - st;
        fired = 1;
      end
      n += st;
    end
    return n;
  endfunction

  task automatic send_stream(input int nb, input int p, input int c0,
                             input int c1, input bit single, input bit en);
    int hc, b;
    cmp_zero = 8'(c0); cmp_one = 8'(c1);
    single_act = single; cnt_en = en;
    chk("R2 ready before load", int'(s_ready), 1);
    s_valid = 1'b1; s_data = bytes[0];
    step();
    s_valid = 1'b0;
    for (int i = 0; i < nb; i++) begin
      for (int j = 0; j < 8; j++) begin
        baud_tick = 1'b1;
        step();
        baud_tick = 1'b0;
        if (j == 0 && i > 0) chk("R10 byte_done at hand-over", int'(byte_done), 1);
        if (j == 0) chk("R3 slot drained at start", int'(s_ready), 1);
        b = int'(bytes[i][7-j]);
        hc = 0;
        for (int k = 0; k < p; k++) begin
          if (pulse_out) hc++;
          if (k == 2) begin cmp_zero = 8'($urandom); cmp_one = 8'($urandom); end
          if (k == p - 2) begin cmp_zero = 8'(c0); cmp_one = 8'(c1); end
          if (j == 3 && i + 1 < nb) begin
            if (k == 1) begin s_valid = 1'b1; s_data = bytes[i+1]; end
            if (k == 2) begin
              s_valid = 1'b0;
              chk("R2 ready low when full", int'(s_ready), 0);
            end
            if (k == 3) begin s_valid = 1'b1; s_data = ~bytes[i+1]; end
            if (k == 4) s_valid = 1'b0;
          end
          if (k < p - 1) step();
        end
        chk($sformatf("R5 R4 R9 width byte %0d bit %0d", i, j), hc,
            exp_high(b ? c1 : c0, p, single, en));
      end
    end
    baud_tick = 1'b1;
    step();
    baud_tick = 1'b0;
    chk("R10 byte_done after last bit", int'(byte_done), 1);
    chk("R10 output low at end", int'(pulse_out), 0);
    step();
    chk("R10 byte_done one cycle", int'(byte_done), 0);
    chk("R1 idle after stream", int'(pulse_out), 0);
    cnt_en = 1'b1;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    step(); step();
    rst_n = 1'b1;
    step();
    chk("R1 reset pulse_out", int'(pulse_out), 0);
    chk("R1 reset byte_done", int'(byte_done), 0);
    chk("R1 reset s_ready", int'(s_ready), 1);
    for (int t = 0; t < 3; t++) begin
      baud_tick = 1'b1; step(); baud_tick = 1'b0; step();
      chk("R1 idle tick keeps low", int'(pulse_out), 0);
    end
    // bit order and selection
    bytes[0] = 8'hA5;
    send_stream(1, 20, 5, 12, 1'b1, 1'b1);
    // zero width for 0 bits (R6)
    bytes[0] = 8'h3C;
    send_stream(1, 16, 0, 7, 1'b1, 1'b1);
    // width beyond bit period
    bytes[0] = 8'h96;
    send_stream(1, 20, 4, 30, 1'b1, 1'b1);
    // frozen counter (R7)
    bytes[0] = 8'h5A;
    send_stream(1, 12, 3, 6, 1'b1, 1'b0);
    // wrap-around, repeat vs single-action (R8)
    bytes[0] = 8'hC3;
    send_stream(1, 600, 10, 40, 1'b0, 1'b1);
    send_stream(1, 600, 10, 40, 1'b1, 1'b1);
    // chained stream
    bytes[0] = 8'h81; bytes[1] = 8'h7E; bytes[2] = 8'h00;
    send_stream(3, 24, 9, 17, 1'b1, 1'b1);
    // random mix
    for (int r = 0; r < 20; r++) begin
      int nb;
      nb = 1 + int'($urandom % 3);
      for (int q = 0; q < nb; q++) bytes[q] = 8'($urandom);
      send_stream(nb, 8 + int'($urandom % 63), int'($urandom % 81),
                  int'($urandom % 81), 1'($urandom), 1'b1);
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule